// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO with Mailboxes

This block joins two clock domains, port A and port B, each with its own clock and its own active-low asynchronous reset. Two asynchronous FIFOs of 64 words by 36 bits run in opposite directions. One takes words written at A and delivers them at B. The other takes words written at B and delivers them at A. Read and write pointers cross between the domains in Gray code through two-stage synchronizers. Each domain's flags come only from its own pointer and the synchronized copy of the other side's pointer. Full and almost-full belong to the writing port. Empty and almost-empty belong to the reading port.

Each direction also has a single-word mailbox that does not use the FIFO. A mailbox write at one port raises a mail flag at the other port. A mailbox read there returns the word and clears the flag. Every 36-bit word is treated as four 9-bit lanes. The top bit of each lane is parity over the eight bits below it. Each port checks the parity of every word it writes and reports errors without stopping the transfer. Each port can also replace the parity bits of the word it reads with freshly computed ones.

Top module: `bidir_fifo_mbox`

## Requirements
- R1: Words written at port A with `a_wr_en` high (and `a_mb_wr` low) are returned at port B by `b_rd_en`, in the order written and unmodified when `b_par_gen` is 0. `b_rd_data` shows the word from the rising `clk_b` edge that performs the read.
- R2: Words written at port B are returned at port A in the same way.
- R3: `a_full` asserts right after the 64th unread word is written. Further writes while full are ignored and never appear at the read side.
- R4: A read while the read side is empty is ignored: the read data holds its value and empty stays asserted.
- R5: `a_afull` is 1 when the number of free slots, counted with the synchronized read pointer, is at most `a_af_gap`. `b_afull` is the same for the other FIFO.
- R6: `b_aempty` is 1 when the number of stored words seen at port B is at most `b_ae_gap`. `a_aempty` is the same at port A.
- R7: A write with `a_mb_wr` high goes to the A-to-B mailbox and not to the FIFO. After synchronization `b_mail` rises. `b_mb_rd` while `b_mail` is 1 returns the word and clears `b_mail` on the next cycle. The same holds from B to A. A mailbox read takes priority over a FIFO read in the same cycle.
- R8: `b_mb_rd` while `b_mail` is 0 is ignored: `b_rd_data` holds its value.
- R9: Lane k occupies bits 9k+8..9k, and bit 9k+8 is its parity bit. With `x_par_odd` = 1 a lane is correct when its nine bits hold an odd number of ones; with 0, an even number. `x_perr` is 1 during any write cycle (FIFO or mailbox) in which a lane of `x_wr_data` is wrong. The word is stored anyway.
- R10: With `x_par_gen` = 1, each lane's parity bit on `x_rd_data` is recomputed from its eight data bits for the port's `x_par_odd` setting. With 0 the stored word is output as is.
- R11: After reset both FIFOs are empty: empty and almost-empty are 1, full and almost-full are 0 (for gaps below 64), the mail flags are 0 and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| a_par_odd | input | 1 | Port A parity sense: 1 odd, 0 even |
| a_par_gen | input | 1 | Port A regenerates parity on read data |
| a_af_gap | input | 7 | Free-slot threshold for a_afull |
| a_ae_gap | input | 7 | Word-count threshold for a_aempty |
| a_wr_en | input | 1 | Write a_wr_data into the A-to-B FIFO |
| a_mb_wr | input | 1 | Write a_wr_data into the A-to-B mailbox instead |
| a_wr_data | input | 36 | Port A write word |
| a_rd_en | input | 1 | Read the B-to-A FIFO |
| a_mb_rd | input | 1 | Read the B-to-A mailbox |
| a_rd_data | output | 36 | Port A read word |
| a_full | output | 1 | A-to-B FIFO full |
| a_afull | output | 1 | A-to-B FIFO almost full |
| a_empty | output | 1 | B-to-A FIFO empty |
| a_aempty | output | 1 | B-to-A FIFO almost empty |
| a_mail | output | 1 | B-to-A mailbox holds unread mail |
| a_perr | output | 1 | Parity error on the current port A write |
| b_par_odd | input | 1 | Port B parity sense: 1 odd, 0 even |
| b_par_gen | input | 1 | Port B regenerates parity on read data |
| b_af_gap | input | 7 | Free-slot threshold for b_afull |
| b_ae_gap | input | 7 | Word-count threshold for b_aempty |
| b_wr_en | input | 1 | Write b_wr_data into the B-to-A FIFO |
| b_mb_wr | input | 1 | Write b_wr_data into the B-to-A mailbox instead |
| b_wr_data | input | 36 | Port B write word |
| b_rd_en | input | 1 | Read the A-to-B FIFO |
| b_mb_rd | input | 1 | Read the A-to-B mailbox |
| b_rd_data | output | 36 | Port B read word |
| b_full | output | 1 | B-to-A FIFO full |
| b_afull | output | 1 | B-to-A FIFO almost full |
| b_empty | output | 1 | A-to-B FIFO empty |
| b_aempty | output | 1 | A-to-B FIFO almost empty |
| b_mail | output | 1 | A-to-B mailbox holds unread mail |
| b_perr | output | 1 | Parity error on the current port B write |

## Verification
The A-to-B path is driven with a table of words in both parity senses. Some words have correct parity and some have one, two or all four lanes corrupted. This shows whether the error output follows the lane count and sense, and whether a bad word still travels unchanged. A full 64-word fill with a 65th write separates correct full handling from overflow. Draining it one word at a time walks the almost-empty threshold and ends with a read on an empty FIFO. Mailbox traffic in both directions, plus a mailbox read with no mail, separates the mailbox path from the FIFO path. Reading one corrupted word with generation on, and one with generation off, separates regenerated parity from parity passed through.

// File: rtl/bdx_pkg.sv
package bdx_pkg;
   parameter int unsigned WORD_W      = 36;
   parameter int unsigned LANE_W      = 9;
   parameter int unsigned FIFO_AW     = 6;
   parameter int unsigned SYNC_STAGES = 2;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_FIFO = 2'd1,
      SRC_MBOX = 2'd2
   } rd_src_e;
endpackage

// File: rtl/bdx_sync.sv
module bdx_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/bdx_afifo.sv
module bdx_afifo #(
   parameter int WIDTH = 36,
   parameter int AW    = 6,
   parameter int SYNC  = 2
) (
   input  logic             wclk,
   input  logic             wrst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW:0]      af_gap,
   output logic             full,
   output logic             afull,
   input  logic             rclk,
   input  logic             rrst_n,
   input  logic             rd,
   output logic [WIDTH-1:0] rword,
   input  logic [AW:0]      ae_gap,
   output logic             empty,
   output logic             aempty
);
   localparam int         DEPTH   = 1 << AW;
   localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

   function automatic logic [AW:0] to_gray(input logic [AW:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
      return b;
   endfunction

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0] wbin, wgray, rbin, rgray;
   logic [AW:0] rg_w, wg_r, rb_w, wb_r, wcnt, rcnt;
   logic        wfire, rfire;

   assign wfire = wr && !full;
   assign rfire = rd && !empty;

   // write domain
   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wfire) begin
         wbin  <= wbin + 1'b1;
         wgray <= to_gray(wbin + 1'b1);
      end
   end

   always_ff @(posedge wclk) begin
      if (wfire) mem[wbin[AW-1:0]] <= wdata;
   end

   bdx_sync #(.W(AW+1), .STAGES(SYNC)) u_rptr_sync (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rg_w));

   assign rb_w  = from_gray(rg_w);
   assign wcnt  = wbin - rb_w;
   assign full  = (wcnt == DEPTH_C);
   assign afull = ((DEPTH_C - wcnt) <= af_gap);

   // read domain
   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rfire) begin
         rbin  <= rbin + 1'b1;
         rgray <= to_gray(rbin + 1'b1);
      end
   end

   bdx_sync #(.W(AW+1), .STAGES(SYNC)) u_wptr_sync (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wg_r));

   assign wb_r   = from_gray(wg_r);
   assign rcnt   = wb_r - rbin;
   assign empty  = (rcnt == '0);
   assign aempty = (rcnt <= ae_gap);
   assign rword  = mem[rbin[AW-1:0]];

   // assertions
   p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr && full) |=> $stable(wbin));
   p_count_bound_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
      wcnt <= DEPTH_C);
   p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd && empty) |=> $stable(rbin));
   p_full_implies_afull_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
      full |-> afull);
   p_empty_implies_aempty_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
      empty |-> aempty);
   p_gray_step_r1: assert property (@(posedge wclk) disable iff (!wrst_n)
      $countones(wgray ^ $past(wgray)) <= 1);
   p_gray_step_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/bdx_mbox.sv
module bdx_mbox #(
   parameter int W    = 36,
   parameter int SYNC = 2
) (
   input  logic         wclk,
   input  logic         wrst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         rclk,
   input  logic         rrst_n,
   input  logic         take,
   output logic         mail,
   output logic [W-1:0] rdata
);
   logic         wtog, stog, ack;
   logic [W-1:0] hold;

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wtog <= 1'b0;
         hold <= '0;
      end else if (we) begin
         wtog <= ~wtog;
         hold <= wdata;
      end
   end

   bdx_sync #(.W(1), .STAGES(SYNC)) u_tog_sync (
      .clk(rclk), .rst_n(rrst_n), .d(wtog), .q(stog));

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n)   ack <= 1'b0;
      else if (take) ack <= stog;
   end

   assign mail  = stog ^ ack;
   assign rdata = hold;

   p_mail_clear_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
      (take && mail) |=> (!mail || !$stable(stog)));
   p_take_needs_mail_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
      take |-> mail);
endmodule

// File: rtl/bdx_par.sv
module bdx_par #(
   parameter int W    = 36,
   parameter int LANE = 9
) (
   input  logic         odd,
   input  logic         gen,
   input  logic         chk_en,
   input  logic [W-1:0] chk_word,
   input  logic [W-1:0] raw_out,
   output logic         perr,
   output logic [W-1:0] out_word
);
   localparam int NL = W / LANE;
   logic [NL-1:0] bad;

   for (genvar g = 0; g < NL; g++) begin : g_lane
      localparam int LO = g * LANE;
      assign bad[g] = (^chk_word[LO +: LANE]) != odd;
      assign out_word[LO +: LANE-1] = raw_out[LO +: LANE-1];
      assign out_word[LO+LANE-1]    = gen ? ((^raw_out[LO +: LANE-1]) ^ odd)
                                          : raw_out[LO+LANE-1];
   end

   assign perr = chk_en && (|bad);
endmodule

// File: rtl/bidir_fifo_mbox.sv
module bidir_fifo_mbox
   import bdx_pkg::*;
#(
   parameter int DW   = bdx_pkg::WORD_W,
   parameter int LW   = bdx_pkg::LANE_W,
   parameter int AW   = bdx_pkg::FIFO_AW,
   parameter int SYNC = bdx_pkg::SYNC_STAGES
) (
   input  logic          clk_a,
   input  logic          rst_a_n,
   input  logic          clk_b,
   input  logic          rst_b_n,
   input  logic          a_par_odd,
   input  logic          a_par_gen,
   input  logic [AW:0]   a_af_gap,
   input  logic [AW:0]   a_ae_gap,
   input  logic          a_wr_en,
   input  logic          a_mb_wr,
   input  logic [DW-1:0] a_wr_data,
   input  logic          a_rd_en,
   input  logic          a_mb_rd,
   output logic [DW-1:0] a_rd_data,
   output logic          a_full,
   output logic          a_afull,
   output logic          a_empty,
   output logic          a_aempty,
   output logic          a_mail,
   output logic          a_perr,
   input  logic          b_par_odd,
   input  logic          b_par_gen,
   input  logic [AW:0]   b_af_gap,
   input  logic [AW:0]   b_ae_gap,
   input  logic          b_wr_en,
   input  logic          b_mb_wr,
   input  logic [DW-1:0] b_wr_data,
   input  logic          b_rd_en,
   input  logic          b_mb_rd,
   output logic [DW-1:0] b_rd_data,
   output logic          b_full,
   output logic          b_afull,
   output logic          b_empty,
   output logic          b_aempty,
   output logic          b_mail,
   output logic          b_perr
);
   if (DW % LW != 0) begin : g_bad_lane
      $error("word width must be a whole number of lanes");
   end
   if (LW < 2) begin : g_bad_lane_w
      $error("a lane needs at least one data bit and one parity bit");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end

   rd_src_e      a_src, b_src;
   logic [DW-1:0] ab_word, ba_word, ab_mb, ba_mb, a_q, b_q;

   always_comb begin
      if (a_mb_rd && a_mail)       a_src = SRC_MBOX;
      else if (a_rd_en && !a_empty) a_src = SRC_FIFO;
      else                          a_src = SRC_NONE;
   end

   always_comb begin
      if (b_mb_rd && b_mail)       b_src = SRC_MBOX;
      else if (b_rd_en && !b_empty) b_src = SRC_FIFO;
      else                          b_src = SRC_NONE;
   end

   // A to B
   bdx_afifo #(.WIDTH(DW), .AW(AW), .SYNC(SYNC)) u_fifo_ab (
      .wclk(clk_a), .wrst_n(rst_a_n), .wr(a_wr_en && !a_mb_wr), .wdata(a_wr_data),
      .af_gap(a_af_gap), .full(a_full), .afull(a_afull),
      .rclk(clk_b), .rrst_n(rst_b_n), .rd(b_src == SRC_FIFO), .rword(ab_word),
      .ae_gap(b_ae_gap), .empty(b_empty), .aempty(b_aempty));

   // B to A
   bdx_afifo #(.WIDTH(DW), .AW(AW), .SYNC(SYNC)) u_fifo_ba (
      .wclk(clk_b), .wrst_n(rst_b_n), .wr(b_wr_en && !b_mb_wr), .wdata(b_wr_data),
      .af_gap(b_af_gap), .full(b_full), .afull(b_afull),
      .rclk(clk_a), .rrst_n(rst_a_n), .rd(a_src == SRC_FIFO), .rword(ba_word),
      .ae_gap(a_ae_gap), .empty(a_empty), .aempty(a_aempty));

   bdx_mbox #(.W(DW), .SYNC(SYNC)) u_mbox_ab (
      .wclk(clk_a), .wrst_n(rst_a_n), .we(a_mb_wr), .wdata(a_wr_data),
      .rclk(clk_b), .rrst_n(rst_b_n), .take(b_src == SRC_MBOX),
      .mail(b_mail), .rdata(ab_mb));

   bdx_mbox #(.W(DW), .SYNC(SYNC)) u_mbox_ba (
      .wclk(clk_b), .wrst_n(rst_b_n), .we(b_mb_wr), .wdata(b_wr_data),
      .rclk(clk_a), .rrst_n(rst_a_n), .take(a_src == SRC_MBOX),
      .mail(a_mail), .rdata(ba_mb));

   always_ff @(posedge clk_a or negedge rst_a_n) begin
      if (!rst_a_n) a_q <= '0;
      else begin
         case (a_src)
            SRC_MBOX: a_q <= ba_mb;
            SRC_FIFO: a_q <= ba_word;
            default:  a_q <= a_q;
         endcase
      end
   end

   always_ff @(posedge clk_b or negedge rst_b_n) begin
      if (!rst_b_n) b_q <= '0;
      else begin
         case (b_src)
            SRC_MBOX: b_q <= ab_mb;
            SRC_FIFO: b_q <= ab_word;
            default:  b_q <= b_q;
         endcase
      end
   end

   bdx_par #(.W(DW), .LANE(LW)) u_par_a (
      .odd(a_par_odd), .gen(a_par_gen), .chk_en(a_wr_en || a_mb_wr),
      .chk_word(a_wr_data), .raw_out(a_q), .perr(a_perr), .out_word(a_rd_data));

   bdx_par #(.W(DW), .LANE(LW)) u_par_b (
      .odd(b_par_odd), .gen(b_par_gen), .chk_en(b_wr_en || b_mb_wr),
      .chk_word(b_wr_data), .raw_out(b_q), .perr(b_perr), .out_word(b_rd_data));

   p_rd_hold_a_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (a_src == SRC_NONE) |=> $stable(a_q));
   p_rd_hold_b_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (b_src == SRC_NONE) |=> $stable(b_q));
   p_mbox_prio_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (b_mb_rd && b_mail && b_rd_en && !b_empty) |=> $stable(u_fifo_ab.rbin));
endmodule

// File: tb/tb_bidir_fifo_mbox.sv
module tb_bidir_fifo_mbox;
   localparam int DW = 36;
   localparam int AW = 6;

   logic clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
   logic a_par_odd = 1, a_par_gen = 0, b_par_odd = 1, b_par_gen = 0;
   logic [AW:0] a_af_gap = 7'd4, a_ae_gap = 7'd2, b_af_gap = 7'd4, b_ae_gap = 7'd2;
   logic a_wr_en = 0, a_mb_wr = 0, a_rd_en = 0, a_mb_rd = 0;
   logic b_wr_en = 0, b_mb_wr = 0, b_rd_en = 0, b_mb_rd = 0;
   logic [DW-1:0] a_wr_data = '0, b_wr_data = '0;
   logic [DW-1:0] a_rd_data, b_rd_data;
   logic a_full, a_afull, a_empty, a_aempty, a_mail, a_perr;
   logic b_full, b_afull, b_empty, b_aempty, b_mail, b_perr;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   always #5 clk_a = ~clk_a;
   initial begin #3; forever #5 clk_b = ~clk_b; end

   bidir_fifo_mbox dut (.*);

   // {odd, lane corruption mask, base word}
   localparam logic [40:0] VEC [8] = '{
      {1'b1, 4'h0, 36'h0_0000_0000},
      {1'b1, 4'h0, 36'hF_FFFF_FFFF},
      {1'b0, 4'h0, 36'h1_2345_6789},
      {1'b0, 4'h1, 36'h5_5555_5555},
      {1'b1, 4'h8, 36'hA_AAAA_AAAA},
      {1'b0, 4'hF, 36'h0_F0F0_F0F0},
      {1'b1, 4'h6, 36'h3_C3C3_C3C3},
      {1'b0, 4'h0, 36'h8_0808_0808}
   };

   function automatic logic [DW-1:0] fix_par(logic [DW-1:0] d, logic odd);
      for (int k = 0; k < 4; k++) d[9*k+8] = (^d[9*k +: 8]) ^ odd;
      return d;
   endfunction

   function automatic logic [DW-1:0] spoil(logic [DW-1:0] d, logic [3:0] m);
      for (int k = 0; k < 4; k++) if (m[k]) d[9*k+8] = ~d[9*k+8];
      return d;
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic a_push(logic [DW-1:0] d, logic mb);
      @(posedge clk_a); #1;
      a_wr_en = !mb; a_mb_wr = mb; a_wr_data = d;
      @(posedge clk_a); #1;
      a_wr_en = 0; a_mb_wr = 0;
   endtask

   task automatic b_push(logic [DW-1:0] d, logic mb);
      @(posedge clk_b); #1;
      b_wr_en = !mb; b_mb_wr = mb; b_wr_data = d;
      @(posedge clk_b); #1;
      b_wr_en = 0; b_mb_wr = 0;
   endtask

   task automatic b_pop(logic mb);
      @(posedge clk_b); #1;
      b_rd_en = !mb; b_mb_rd = mb;
      @(posedge clk_b); #1;
      b_rd_en = 0; b_mb_rd = 0;
   endtask

   task automatic a_pop(logic mb);
      @(posedge clk_a); #1;
      a_rd_en = !mb; a_mb_rd = mb;
      @(posedge clk_a); #1;
      a_rd_en = 0; a_mb_rd = 0;
   endtask

   task automatic settle();
      repeat (6) @(posedge clk_b);
      repeat (6) @(posedge clk_a);
      #2;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      repeat (200000) @(posedge clk_a);
      if (!done) begin
         vectors++; miscompares++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] w, last;
      repeat (3) @(posedge clk_a);
      #1; rst_a_n = 1; rst_b_n = 1;
      #2;
      // R11 reset state
      check("R11 b_empty", 36'(b_empty), 36'd1);
      check("R11 a_empty", 36'(a_empty), 36'd1);
      check("R11 b_aempty", 36'(b_aempty), 36'd1);
      check("R11 a_full", 36'(a_full), 36'd0);
      check("R11 a_afull", 36'(a_afull), 36'd0);
      check("R11 mail", 36'({a_mail, b_mail}), 36'd0);
      check("R11 rd_data", b_rd_data, 36'd0);

      // R1 / R9 vector table
      for (int i = 0; i < 8; i++) begin
         logic [DW-1:0] word;
         word = spoil(fix_par(VEC[i][35:0], VEC[i][40]), VEC[i][39:36]);
         @(posedge clk_a); #1;
         a_par_odd = VEC[i][40]; a_wr_en = 1; a_wr_data = word;
         #2;
         check("R9 a_perr", 36'(a_perr), 36'(VEC[i][39:36] != 4'h0));
         @(posedge clk_a); #1;
         a_wr_en = 0;
      end
      settle();
      for (int i = 0; i < 8; i++) begin
         b_pop(0);
         check("R1 order/data", b_rd_data,
               spoil(fix_par(VEC[i][35:0], VEC[i][40]), VEC[i][39:36]));
      end
      check("R4 b_empty after drain", 36'(b_empty), 36'd1);

      // R2 B to A
      for (int i = 0; i < 3; i++) b_push(36'h7_0000_0000 + 36'(i * 37), 0);
      settle();
      for (int i = 0; i < 3; i++) begin
         a_pop(0);
         check("R2 order/data", a_rd_data, 36'h7_0000_0000 + 36'(i * 37));
      end

      // R3 / R5 fill
      for (int i = 0; i < 64; i++) begin
         a_push(36'h1_0000_0000 + 36'(i * 36'h1001), 0);
         if (i == 58) check("R5 afull at 5 free", 36'(a_afull), 36'd0);
         if (i == 59) check("R5 afull at 4 free", 36'(a_afull), 36'd1);
         if (i == 62) check("R3 not yet full", 36'(a_full), 36'd0);
      end
      check("R3 full", 36'(a_full), 36'd1);
      a_push(36'hD_EADB_EEF0, 0);
      check("R3 still full", 36'(a_full), 36'd1);
      settle();
      check("R6 b_aempty with 64", 36'(b_aempty), 36'd0);
      for (int i = 0; i < 64; i++) begin
         b_pop(0);
         check("R3 drain data", b_rd_data, 36'h1_0000_0000 + 36'(i * 36'h1001));
         if (i == 60) check("R6 aempty at 3", 36'(b_aempty), 36'd0);
         if (i == 61) check("R6 aempty at 2", 36'(b_aempty), 36'd1);
      end
      check("R3 overflow word dropped", 36'(b_empty), 36'd1);
      last = b_rd_data;
      b_pop(0);
      check("R4 read on empty holds", b_rd_data, last);
      check("R4 empty stays", 36'(b_empty), 36'd1);

      // R10 generation
      a_par_odd = 1;
      w = spoil(fix_par(36'h2_4681_3579, 1'b1), 4'h5);
      a_push(w, 0);
      a_push(w, 0);
      settle();
      b_par_odd = 1; b_par_gen = 1;
      b_pop(0);
      check("R10 gen on", b_rd_data, fix_par(36'h2_4681_3579, 1'b1));
      b_par_gen = 0;
      b_pop(0);
      check("R10 gen off", b_rd_data, w);
      b_par_odd = 0; b_par_gen = 1;
      #1;
      check("R10 gen even", b_rd_data, fix_par(36'h2_4681_3579, 1'b0));
      b_par_gen = 0; b_par_odd = 1;

      // R7 / R8 mailboxes
      a_push(36'h9_1357_2468, 1);
      settle();
      check("R7 mailbox bypasses fifo", 36'(b_empty), 36'd1);
      check("R7 b_mail set", 36'(b_mail), 36'd1);
      b_pop(1);
      check("R7 mailbox word", b_rd_data, 36'h9_1357_2468);
      check("R7 b_mail cleared", 36'(b_mail), 36'd0);
      b_pop(1);
      check("R8 read without mail", b_rd_data, 36'h9_1357_2468);
      b_push(36'h6_ABCD_0123, 1);
      settle();
      check("R7 a_mail set", 36'(a_mail), 36'd1);
      a_pop(1);
      check("R7 reverse word", a_rd_data, 36'h6_ABCD_0123);
      check("R7 a_mail cleared", 36'(a_mail), 36'd0);

      done = 1;
      summary();
      $finish;
   end
endmodule